// File: doc/BRIEF.md
# Watchdog-Gated Supply Overcurrent Guard

This block decides what a chip does when the regulated supply reports an overcurrent while the watchdog has been switched off by a dedicated OFF trigger code. When the watchdog is turned off in standby, supply-current monitoring is masked for a hold-off interval. That interval is the watchdog period that was running before, or a 4096 ms default when no period was running. Once the hold-off expires, monitoring is live again. An overcurrent then does one of two things, depending on a configuration bit: it requests an immediate reset, or it forces the watchdog back on with its last period.

The block also runs the watchdog itself. Every counter advances only on a 1 ms tick input. A valid trigger selects one of eight periods and restarts the count. A running watchdog that is not serviced raises a one-cycle time-out interrupt. An out-of-table trigger code, or entering sleep while the watchdog is off, requests a reset. The analog current sensing, the main mode controller and the register decoding lie outside this block.

Top module: `supply_guard_wdt`

## Requirements
- R1: After reset, rstReq, wdRunning and wdTimeoutIrq are low. The watchdog is off and armed, with a 4096 ms hold-off and a 4096 ms period.
- R2: A trigger strobe with trigCode 0 to 7 selects a period of 4, 8, 16, 32, 64, 256, 1024 or 4096 ms (code 0 gives 4 ms, code 7 gives 4096 ms). It clears the watchdog count, and wdRunning is high in the next cycle.
- R3: A running watchdog pulses wdTimeoutIrq for one cycle on the period-th tick after the last restart, then starts counting again. Cycles without a tick do not advance it.
- R4: A trigger with code 8 to 14 raises rstReq for one cycle in the next cycle and leaves the watchdog off. It also restores the 4096 ms period and the 4096 ms hold-off.
- R5: A trigger with code 15 (OFF) while modeStandby is high turns the watchdog off in the next cycle and starts a hold-off. The hold-off length is the running period if the watchdog was running, and otherwise the length already held.
- R6: An OFF trigger while modeStandby is low turns the watchdog off and arms the hold-off with the running period. The hold-off starts in the cycle after modeStandby is seen high. After a reset, the armed length is 4096 ms.
- R7: During the hold-off, ocFlag has no effect. The hold-off ends after its length in ticks, because the counter stops at terminal count, and monitoring is live from the next cycle.
- R8: With monitoring live and cfgResetOnOc high, ocFlag raises rstReq for one cycle in the next cycle and restores the defaults.
- R9: With monitoring live and cfgResetOnOc low, ocFlag restarts the watchdog with its last period. The watchdog stays on, and further overcurrents are ignored, until an OFF trigger.
- R10: wdTimeoutIrq is never high while the watchdog is off.
- R11: modeSleep high while the watchdog is off raises rstReq from the next cycle for as long as sleep stays high. While the watchdog runs, sleep causes no reset.
- R12: In one cycle, a trigger strobe takes priority over sleep, and sleep takes priority over the overcurrent flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick1ms | input | 1 | One-cycle strobe every millisecond |
| trigStb | input | 1 | Watchdog trigger write strobe |
| trigCode | input | 4 | Trigger code: 0-7 period, 15 OFF, others invalid |
| modeStandby | input | 1 | Standby mode active or being entered |
| modeSleep | input | 1 | Sleep mode active |
| ocFlag | input | 1 | Supply overcurrent detected |
| cfgResetOnOc | input | 1 | 1: overcurrent resets, 0: overcurrent restarts watchdog |
| rstReq | output | 1 | Reset request |
| wdRunning | output | 1 | Watchdog is counting |
| wdTimeoutIrq | output | 1 | One-cycle watchdog time-out interrupt |

## Verification
The bench probes the edges of the hold-off. An overcurrent late in a 4096 ms hold-off must be ignored, and one just after must act. A design with an off-by-one or non-saturating hold counter would reset early or never leave the mask. The bench checks that an OFF code inherits the running period, while a repeated OFF during hold-off keeps its length and an OFF after reset uses the default. A design that mixed these up would unmask at the wrong time. The restart path is checked to stay on through further overcurrents, and sleep is checked to reset only while the watchdog is off. Sparse ticks confirm that no counter advances on a bare clock cycle.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [1:0] {WD_RUN, WD_ARMED, WD_HOLD, WD_MON} wdState_t;

  typedef struct packed {
    logic       loadCode;
    logic [2:0] code;
    logic       restartWd;
    logic       wdEnable;
    logic       holdEnable;
    logic       startHold;
    logic       holdFromPeriod;
    logic       restoreDefaults;
  } dpCmd_t;

  localparam logic [3:0] OFF_CODE = 4'hF;
endpackage

// File: rtl/sgw_dp.sv
module sgw_dp
  import sgw_pkg::*;
#(
  parameter int CNT_W        = 13,
  parameter int BASE_MS      = 4,
  parameter int DEFAULT_HOLD = 4096
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tick1ms,
  input  dpCmd_t cmd,
  output logic   holdDone,
  output logic   toIrq
);
  localparam logic [CNT_W-1:0] DEF_HOLD = CNT_W'(DEFAULT_HOLD);
  localparam logic [2:0]       DEF_CODE = 3'd7;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  // period in ticks: base shifted by a code-dependent amount
  function automatic logic [CNT_W-1:0] periodOf(input logic [2:0] c);
    int sh;
    case (c)
      3'd0: sh = 0;
      3'd1: sh = 1;
      3'd2: sh = 2;
      3'd3: sh = 3;
      3'd4: sh = 4;
      3'd5: sh = 6;
      3'd6: sh = 8;
      default: sh = 10;
    endcase
    return CNT_W'(BASE_MS << sh);
  endfunction

  logic [2:0]       periodCode;
  logic [CNT_W-1:0] holdLen, wdCnt, holdCnt, curPeriod;
  logic             wdWrap;

  assign curPeriod = periodOf(periodCode);
  assign wdWrap    = (wdCnt == curPeriod - ONE);
  assign holdDone  = (holdCnt >= holdLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCode <= DEF_CODE;
      holdLen    <= DEF_HOLD;
      wdCnt      <= '0;
      holdCnt    <= '0;
      toIrq      <= 1'b0;
    end else begin
      if (cmd.restoreDefaults)    periodCode <= DEF_CODE;
      else if (cmd.loadCode)      periodCode <= cmd.code;

      if (cmd.restoreDefaults)    holdLen <= DEF_HOLD;
      else if (cmd.holdFromPeriod) holdLen <= curPeriod;

      toIrq <= 1'b0;
      if (cmd.restartWd) begin
        wdCnt <= '0;
      end else if (cmd.wdEnable && tick1ms) begin
        if (wdWrap) begin
          wdCnt <= '0;
          toIrq <= 1'b1;
        end else begin
          wdCnt <= wdCnt + ONE;
        end
      end

      // hold-off counter saturates at its terminal count
      if (cmd.startHold)                               holdCnt <= '0;
      else if (cmd.holdEnable && tick1ms && !holdDone) holdCnt <= holdCnt + ONE;
    end
  end
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigStb,
  input  logic [3:0] trigCode,
  input  logic       modeStandby,
  input  logic       modeSleep,
  input  logic       ocFlag,
  input  logic       cfgResetOnOc,
  input  logic       holdDone,
  output dpCmd_t     cmd,
  output logic       rstReq,
  output logic       wdRunning,
  output logic       holdActive,
  output logic       monActive
);
  wdState_t state, nxtState;
  logic     resetNow, isRun, codeOff, codeBad, codeValid;

  assign isRun     = (state == WD_RUN);
  assign codeOff   = (trigCode == OFF_CODE);
  assign codeBad   = trigCode[3] && !codeOff;
  assign codeValid = !trigCode[3];

  always_comb begin
    cmd      = '0;
    nxtState = state;
    resetNow = 1'b0;
    if (trigStb && codeBad) begin
      resetNow = 1'b1;
    end else if (trigStb && codeValid) begin
      cmd.loadCode  = 1'b1;
      cmd.code      = trigCode[2:0];
      cmd.restartWd = 1'b1;
      nxtState      = WD_RUN;
    end else if (trigStb) begin
      cmd.holdFromPeriod = isRun;
      if (modeStandby) begin
        nxtState      = WD_HOLD;
        cmd.startHold = 1'b1;
      end else begin
        nxtState = WD_ARMED;
      end
    end else if (!isRun && modeSleep) begin
      resetNow = 1'b1;
    end else begin
      case (state)
        WD_ARMED: if (modeStandby) begin
          nxtState      = WD_HOLD;
          cmd.startHold = 1'b1;
        end
        WD_HOLD: if (holdDone) nxtState = WD_MON;
        WD_MON: if (ocFlag) begin
          if (cfgResetOnOc) begin
            resetNow = 1'b1;
          end else begin
            cmd.restartWd = 1'b1;
            nxtState      = WD_RUN;
          end
        end
        default: ;
      endcase
    end
    if (resetNow) begin
      cmd.restoreDefaults = 1'b1;
      nxtState            = WD_ARMED;
    end
    cmd.wdEnable   = isRun && (nxtState == WD_RUN);
    cmd.holdEnable = (state == WD_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= WD_ARMED;
      rstReq <= 1'b0;
    end else begin
      state  <= nxtState;
      rstReq <= resetNow;
    end
  end

  assign wdRunning  = isRun;
  assign holdActive = (state == WD_HOLD);
  assign monActive  = (state == WD_MON);
endmodule

// File: rtl/supply_guard_wdt.sv
module supply_guard_wdt
  import sgw_pkg::*;
#(
  parameter int CNT_W        = 13,
  parameter int BASE_MS      = 4,
  parameter int DEFAULT_HOLD = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick1ms,
  input  logic       trigStb,
  input  logic [3:0] trigCode,
  input  logic       modeStandby,
  input  logic       modeSleep,
  input  logic       ocFlag,
  input  logic       cfgResetOnOc,
  output logic       rstReq,
  output logic       wdRunning,
  output logic       wdTimeoutIrq
);
  dpCmd_t cmd;
  logic   holdDone, holdActive, monActive;

  sgw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .trigStb(trigStb), .trigCode(trigCode),
    .modeStandby(modeStandby), .modeSleep(modeSleep), .ocFlag(ocFlag),
    .cfgResetOnOc(cfgResetOnOc), .holdDone(holdDone), .cmd(cmd),
    .rstReq(rstReq), .wdRunning(wdRunning), .holdActive(holdActive),
    .monActive(monActive)
  );

  sgw_dp #(.CNT_W(CNT_W), .BASE_MS(BASE_MS), .DEFAULT_HOLD(DEFAULT_HOLD)) i_dp (
    .clk(clk), .rstN(rstN), .tick1ms(tick1ms), .cmd(cmd),
    .holdDone(holdDone), .toIrq(wdTimeoutIrq)
  );
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker (
  input logic       clk,
  input logic       rstN,
  input logic       trigStb,
  input logic [3:0] trigCode,
  input logic       modeStandby,
  input logic       modeSleep,
  input logic       ocFlag,
  input logic       cfgResetOnOc,
  input logic       rstReq,
  input logic       wdRunning,
  input logic       wdTimeoutIrq,
  input logic       holdActive,
  input logic       monActive
);
  assert_valid_code_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    trigStb && !trigCode[3] |=> wdRunning && !rstReq);

  assert_bad_code_resets_R4: assert property (@(posedge clk) disable iff (!rstN)
    trigStb && trigCode[3] && (trigCode != 4'hF) |=> rstReq && !wdRunning);

  assert_off_in_standby_R5: assert property (@(posedge clk) disable iff (!rstN)
    trigStb && (trigCode == 4'hF) && modeStandby |=> holdActive && !wdRunning);

  assert_hold_masks_oc_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdActive && !trigStb && !modeSleep |=> !rstReq);

  assert_oc_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    monActive && ocFlag && cfgResetOnOc && !trigStb |=> rstReq);

  assert_oc_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    monActive && ocFlag && !cfgResetOnOc && !trigStb && !modeSleep |=> wdRunning && !rstReq);

  assert_irq_only_running_R10: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeoutIrq |-> wdRunning);

  assert_sleep_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wdRunning && modeSleep && !trigStb |=> rstReq && !wdRunning);
endmodule

bind supply_guard_wdt sgw_checker i_chk (.*);

// File: tb/test_supply_guard_wdt.sv
`timescale 1ns/1ps
module test_supply_guard_wdt;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick1ms = 1'b0;
  logic       trigStb = 1'b0;
  logic [3:0] trigCode = 4'd0;
  logic       modeStandby = 1'b0;
  logic       modeSleep = 1'b0;
  logic       ocFlag = 1'b0;
  logic       cfgResetOnOc = 1'b0;
  logic       rstReq, wdRunning, wdTimeoutIrq;

  int    checks = 0;
  int    errors = 0;
  int    tickDiv = 1;
  int    cyc = 0;
  string curReq = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  supply_guard_wdt i_supply_guard_wdt (
    .clk(clk), .rstN(rstN), .tick1ms(tick1ms), .trigStb(trigStb),
    .trigCode(trigCode), .modeStandby(modeStandby), .modeSleep(modeSleep),
    .ocFlag(ocFlag), .cfgResetOnOc(cfgResetOnOc), .rstReq(rstReq),
    .wdRunning(wdRunning), .wdTimeoutIrq(wdTimeoutIrq)
  );

  always @(negedge clk) begin
    cyc++;
    tick1ms = ((cyc % tickDiv) == 0);
  end

  // ---------------- behavioural reference ----------------
  function automatic int msOf(int c);
    case (c)
      0: return 4;    1: return 8;    2: return 16;   3: return 32;
      4: return 64;   5: return 256;  6: return 1024; default: return 4096;
    endcase
  endfunction

  int mState;   // 0 running, 1 armed, 2 hold-off, 3 monitoring
  int mCode, mHold, mWd, mHoldCnt;
  bit eRst, eRun, eIrq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 1; mCode = 7; mHold = 4096; mWd = 0; mHoldCnt = 0;
      eRst = 0; eRun = 0; eIrq = 0;
    end else begin
      int  nxt;
      bit  rq, irq, restart, startH, running;
      nxt = mState; rq = 0; irq = 0; restart = 0; startH = 0;
      running = (mState == 0);
      if (trigStb && trigCode >= 8 && trigCode <= 14) rq = 1;
      else if (trigStb && trigCode < 8) begin
        mCode = int'(trigCode); nxt = 0; restart = 1;
      end else if (trigStb) begin
        if (running) mHold = msOf(mCode);
        if (modeStandby) begin nxt = 2; startH = 1; end else nxt = 1;
      end else if (!running && modeSleep) rq = 1;
      else if (mState == 1 && modeStandby) begin nxt = 2; startH = 1; end
      else if (mState == 2 && mHoldCnt >= mHold) nxt = 3;
      else if (mState == 3 && ocFlag) begin
        if (cfgResetOnOc) rq = 1; else begin nxt = 0; restart = 1; end
      end
      if (rq) begin nxt = 1; mCode = 7; mHold = 4096; end
      if (restart) mWd = 0;
      else if (running && nxt == 0 && tick1ms) begin
        if (mWd == msOf(mCode) - 1) begin mWd = 0; irq = 1; end
        else mWd++;
      end
      if (startH) mHoldCnt = 0;
      else if (mState == 2 && tick1ms && mHoldCnt < mHold) mHoldCnt++;
      mState = nxt;
      eRst = rq; eIrq = irq; eRun = (nxt == 0);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (rstReq !== eRst || wdRunning !== eRun || wdTimeoutIrq !== eIrq) begin
        errors++;
        $display("FAIL %s cycle %0d: rst/run/irq actual %b%b%b expected %b%b%b",
                 curReq, cyc, rstReq, wdRunning, wdTimeoutIrq, eRst, eRun, eIrq);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig(input logic [3:0] c);
    @(negedge clk); trigStb = 1; trigCode = c;
    @(negedge clk); trigStb = 0;
  endtask

  task automatic ocPulse();
    @(negedge clk); ocFlag = 1;
    @(negedge clk); ocFlag = 0;
  endtask

  task automatic gap(output int n);
    while (!wdTimeoutIrq) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!wdTimeoutIrq) begin @(negedge clk); n++; end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish();
  end

  initial begin
    int g, irqs;
    idle(3);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    curReq = "R1";
    chk("R1 rstReq", rstReq, 0);
    chk("R1 wdRunning", wdRunning, 0);
    chk("R1 irq", wdTimeoutIrq, 0);

    curReq = "R2";
    trig(4'd0);
    chk("R2 running after code 0", wdRunning, 1);
    curReq = "R3";
    gap(g); chk("R3 gap 4 ms", g, 4);
    curReq = "R2";
    trig(4'd1);
    gap(g); chk("R2 gap 8 ms", g, 8);

    curReq = "R10";
    trig(4'hF);
    chk("R10 off outside standby", wdRunning, 0);
    irqs = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (wdTimeoutIrq) irqs++; end
    chk("R10 no irq while off", irqs, 0);

    curReq = "R6";
    cfgResetOnOc = 1;
    @(negedge clk); modeStandby = 1;
    idle(2);
    curReq = "R7";
    ocPulse();
    chk("R7 oc masked in hold", rstReq, 0);
    idle(20);
    curReq = "R8";
    ocPulse();
    chk("R8 oc resets", rstReq, 1);
    @(negedge clk);
    chk("R8 reset is one cycle", rstReq, 0);

    curReq = "R6";
    idle(3990);
    ocPulse();
    chk("R6 default hold masks", rstReq, 0);
    idle(120);
    ocPulse();
    chk("R6 default hold expired", rstReq, 1);

    curReq = "R9";
    modeStandby = 0; cfgResetOnOc = 0;
    trig(4'd2);
    @(negedge clk); modeStandby = 1;
    curReq = "R5";
    trig(4'hF);
    chk("R5 off in standby", wdRunning, 0);
    idle(5);
    trig(4'hF);
    idle(14);
    curReq = "R7";
    ocPulse();
    chk("R7 repeated off keeps length", wdRunning, 0);
    idle(4);
    curReq = "R9";
    ocPulse();
    chk("R9 oc restarts", wdRunning, 1);
    gap(g); chk("R9 last period kept", g, 16);
    ocPulse();
    chk("R9 stays on", wdRunning, 1);

    curReq = "R3";
    tickDiv = 3;
    trig(4'd0);
    gap(g); chk("R3 sparse ticks", g, 12);
    tickDiv = 1;

    curReq = "R12";
    @(negedge clk); modeStandby = 0;
    trig(4'hF);
    @(negedge clk); modeSleep = 1; trigStb = 1; trigCode = 4'd3;
    @(negedge clk); trigStb = 0; modeSleep = 0;
    chk("R12 trigger beats sleep", wdRunning, 1);
    chk("R12 no reset", rstReq, 0);

    curReq = "R4";
    trig(4'd9);
    chk("R4 invalid resets", rstReq, 1);
    chk("R4 watchdog off", wdRunning, 0);
    @(negedge clk);
    chk("R4 pulse", rstReq, 0);

    curReq = "R11";
    @(negedge clk); modeSleep = 1;
    idle(3);
    chk("R11 sleep held reset", rstReq, 1);
    @(negedge clk); modeSleep = 0;
    idle(2);
    trig(4'd0);
    @(negedge clk); modeSleep = 1;
    idle(3);
    chk("R11 running ignores sleep", rstReq, 0);
    chk("R11 still running", wdRunning, 1);
    @(negedge clk); modeSleep = 0;
    idle(10);
    finish();
  end
endmodule